// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central bookkeeping unit for a processor core that runs instructions out of order across a small, fixed pool of functional units, without register renaming. Each instruction goes through four phases: it is accepted into a unit, waits until its source operands can be read, executes, and then waits for permission to write its result. The block keeps a status entry per unit and a pending-writer tag per architectural register. It decides, every cycle, which request may enter, which units may read, and which single unit may write.

The front end offers at most one instruction per cycle, in program order, and holds it while `issueReady` is low. The functional units themselves are not part of the block. The controller tells them when to read operands (`readGrant`) and when execution begins (`execStart`). Each unit reports the end of its execution through a one-cycle `unitDone` strobe. The register file commits the result when `writeGrant` is raised and `writeReg` names the destination.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset no unit is occupied. `readGrant`, `execStart` and `writeGrant` are all zero, and `issueReady` is high for any offered instruction.
- R2: Unit codes on `issueUnit` are 0 = integer, 1 = FP add, 2 = FP multiply, 3 = FP divide, and bit k of every grant vector belongs to unit code k. An instruction is refused (`issueReady` low) while its unit is occupied. An instruction for another, free unit is accepted.
- R3: An instruction is refused while any occupied unit has the same destination register. The refusal lasts up to and including the cycle of that unit's write grant. It lifts in the cycle after.
- R4: An accepted instruction whose two sources have no pending writer gets its `readGrant` bit in the cycle right after the accepting clock edge.
- R5: An instruction whose source has a pending writer does not get `readGrant` until the cycle after that writer's write grant. This includes an instruction accepted in the same cycle as that write grant.
- R6: `execStart` for a unit is high for exactly the one cycle after its `readGrant` cycle. A `unitDone` pulse is accepted from that cycle on.
- R7: The cycle after an accepted `unitDone`, the unit raises `writeGrant`, with `writeReg` equal to its destination, unless R8 or R9 hold it back. The cycle after its write grant, the unit can accept a new instruction.
- R8: A finished unit is not granted its write while another occupied unit still has to read that same register as an available, not yet read, source. The write is granted in the cycle after that reader's `readGrant`.
- R9: At most one `writeGrant` bit is high per cycle. When several units are eligible, the lowest unit code wins, and the others follow in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Front end offers an instruction |
| issueUnit | input | 2 | Unit code of the offered instruction |
| issueDst | input | 5 | Destination register |
| issueSrc1 | input | 5 | First source register |
| issueSrc2 | input | 5 | Second source register |
| unitDone | input | 4 | Per-unit end-of-execution strobe |
| issueReady | output | 1 | The offered instruction is accepted at the next edge if valid |
| readGrant | output | 4 | Per-unit permission to read operands this cycle |
| execStart | output | 4 | Per-unit start-of-execution pulse |
| writeGrant | output | 4 | One-hot permission to write the result this cycle |
| writeReg | output | 5 | Destination register of the granted write |

## Verification
Each result has a fixed distance from the stimulus that causes it:
- `readGrant` appears one cycle after the accepting edge, or one cycle after the blocking writer's write grant.
- `execStart` appears one cycle after `readGrant`.
- `writeGrant` appears one cycle after the accepted `unitDone`, or one cycle after the last blocking reader's `readGrant`.

The bench drives every input just after a falling edge and checks the outputs in the same low half-cycle. It walks each scenario one clock at a time and compares the grant vectors in exactly the cycle where each is due. A monitor also matches every write grant, in order, against a queue of expected unit and register pairs that the driver fills as it creates each instruction.

// File: rtl/scb_pkg.sv
package scb_pkg;
  parameter int UNIT_CNT = 4;
  parameter int REG_CNT  = 32;

  localparam int UNIT_W = $clog2(UNIT_CNT);
  localparam int REG_W  = $clog2(REG_CNT);
  localparam int TAG_W  = $clog2(UNIT_CNT + 1);

  typedef logic [UNIT_W-1:0] unit_t;
  typedef logic [REG_W-1:0]  reg_t;
  typedef logic [TAG_W-1:0]  tag_t;   // 0 = no pending producer, k+1 = unit k

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_EXEC,
    PH_WRITE
  } phase_e;

  // strobes from the control FSMs to the status table
  typedef struct packed {
    logic                issueDo;
    unit_t               issueUnit;
    logic [UNIT_CNT-1:0] readDo;
    logic [UNIT_CNT-1:0] writeDo;
  } strobe_t;

  typedef struct packed {
    logic busy;
    reg_t dst;
    reg_t src1;
    reg_t src2;
    tag_t q1;
    tag_t q2;
    logic rdy1;
    logic rdy2;
  } unit_entry_t;
endpackage

// File: rtl/scb_table.sv
module scb_table
  import scb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  reg_t                issueDst,
  input  reg_t                issueSrc1,
  input  reg_t                issueSrc2,
  output logic [UNIT_CNT-1:0] unitBusy,
  output logic [UNIT_CNT-1:0] opsReady,
  output logic [UNIT_CNT-1:0] warFree,
  output logic                wawHit,
  output reg_t                writeReg
);

  unit_entry_t tbl [UNIT_CNT];
  tag_t        regStat [REG_CNT];

  tag_t writeTag;
  tag_t issueTag;
  tag_t fwdQ1;
  tag_t fwdQ2;

  // tag and destination of the unit granted the write this cycle
  always_comb begin
    writeTag = '0;
    writeReg = '0;
    for (int u = 0; u < UNIT_CNT; u++) begin
      if (strb.writeDo[u]) begin
        writeTag = writeTag | tag_t'(u + 1);
        writeReg = writeReg | tbl[u].dst;
      end
    end
  end

  // producer lookup for the incoming instruction, bypassing a write in flight
  always_comb begin
    issueTag = tag_t'(strb.issueUnit) + tag_t'(1);
    fwdQ1    = regStat[issueSrc1];
    fwdQ2    = regStat[issueSrc2];
    if (writeTag != '0 && fwdQ1 == writeTag) fwdQ1 = '0;
    if (writeTag != '0 && fwdQ2 == writeTag) fwdQ2 = '0;
  end

  // WAW: any occupied unit already targeting the offered destination
  always_comb begin
    wawHit = 1'b0;
    for (int u = 0; u < UNIT_CNT; u++)
      if (tbl[u].busy && tbl[u].dst == issueDst) wawHit = 1'b1;
  end

  // per-unit RAW and WAR views, all units in parallel
  always_comb begin
    for (int u = 0; u < UNIT_CNT; u++) begin
      unitBusy[u] = tbl[u].busy;
      opsReady[u] = tbl[u].busy && tbl[u].rdy1 && tbl[u].rdy2;
      warFree[u]  = 1'b1;
      for (int j = 0; j < UNIT_CNT; j++) begin
        if (j != u && tbl[j].busy &&
            ((tbl[j].rdy1 && tbl[j].src1 == tbl[u].dst) ||
             (tbl[j].rdy2 && tbl[j].src2 == tbl[u].dst)))
          warFree[u] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < UNIT_CNT; u++) tbl[u] <= '0;
      for (int r = 0; r < REG_CNT; r++) regStat[r] <= '0;
    end else begin
      for (int u = 0; u < UNIT_CNT; u++) begin
        if (writeTag != '0 && tbl[u].busy) begin
          if (tbl[u].q1 == writeTag) begin
            tbl[u].q1   <= '0;
            tbl[u].rdy1 <= 1'b1;
          end
          if (tbl[u].q2 == writeTag) begin
            tbl[u].q2   <= '0;
            tbl[u].rdy2 <= 1'b1;
          end
        end
        if (strb.readDo[u]) begin
          tbl[u].rdy1 <= 1'b0;
          tbl[u].rdy2 <= 1'b0;
        end
        if (strb.writeDo[u]) tbl[u].busy <= 1'b0;
        if (strb.issueDo && strb.issueUnit == unit_t'(u)) begin
          tbl[u].busy <= 1'b1;
          tbl[u].dst  <= issueDst;
          tbl[u].src1 <= issueSrc1;
          tbl[u].src2 <= issueSrc2;
          tbl[u].q1   <= fwdQ1;
          tbl[u].q2   <= fwdQ2;
          tbl[u].rdy1 <= (fwdQ1 == '0);
          tbl[u].rdy2 <= (fwdQ2 == '0);
        end
      end
      if (writeTag != '0 && regStat[writeReg] == writeTag) regStat[writeReg] <= '0;
      if (strb.issueDo) regStat[issueDst] <= issueTag;
    end
  end

  // R2
  issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.issueDo |-> !unitBusy[strb.issueUnit]);

  // R3
  issue_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.issueDo |-> !wawHit);

  for (genvar g = 0; g < UNIT_CNT; g++) begin : gChk
    // R8
    write_war_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.writeDo[g] |-> warFree[g]);
    // R7
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strb.writeDo[g] |=> !unitBusy[g]);
  end

endmodule

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  unit_t               issueUnit,
  input  logic [UNIT_CNT-1:0] unitDone,
  input  logic [UNIT_CNT-1:0] unitBusy,
  input  logic [UNIT_CNT-1:0] opsReady,
  input  logic [UNIT_CNT-1:0] warFree,
  input  logic                wawHit,
  output logic                issueReady,
  output strobe_t             strb,
  output logic [UNIT_CNT-1:0] readGrant,
  output logic [UNIT_CNT-1:0] execStart,
  output logic [UNIT_CNT-1:0] writeGrant
);

  phase_e              phase [UNIT_CNT];
  logic [UNIT_CNT-1:0] writeCand;
  logic                issueDo;

  assign issueReady = !unitBusy[issueUnit] && !wawHit;
  assign issueDo    = issueValid && issueReady;

  always_comb begin
    for (int u = 0; u < UNIT_CNT; u++) begin
      readGrant[u] = (phase[u] == PH_READ) && opsReady[u];
      writeCand[u] = (phase[u] == PH_WRITE) && warFree[u];
    end
  end

  // fixed priority: lowest unit code writes first
  always_comb begin
    writeGrant = '0;
    for (int u = UNIT_CNT - 1; u >= 0; u--)
      if (writeCand[u]) writeGrant = UNIT_CNT'(1) << u;
  end

  always_comb begin
    strb.issueDo   = issueDo;
    strb.issueUnit = issueUnit;
    strb.readDo    = readGrant;
    strb.writeDo   = writeGrant;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      execStart <= '0;
      for (int u = 0; u < UNIT_CNT; u++) phase[u] <= PH_IDLE;
    end else begin
      execStart <= readGrant;
      for (int u = 0; u < UNIT_CNT; u++) begin
        unique case (phase[u])
          PH_IDLE:  if (issueDo && issueUnit == unit_t'(u)) phase[u] <= PH_READ;
          PH_READ:  if (readGrant[u])  phase[u] <= PH_EXEC;
          PH_EXEC:  if (unitDone[u])   phase[u] <= PH_WRITE;
          PH_WRITE: if (writeGrant[u]) phase[u] <= PH_IDLE;
          default:  phase[u] <= PH_IDLE;
        endcase
      end
    end
  end

  // R9
  write_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(writeGrant));

  for (genvar g = 0; g < UNIT_CNT; g++) begin : gChk
    // R6
    exec_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      execStart[g] |-> phase[g] == PH_EXEC);
  end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import scb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  logic [UNIT_W-1:0]   issueUnit,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [REG_W-1:0]    issueSrc1,
  input  logic [REG_W-1:0]    issueSrc2,
  input  logic [UNIT_CNT-1:0] unitDone,
  output logic                issueReady,
  output logic [UNIT_CNT-1:0] readGrant,
  output logic [UNIT_CNT-1:0] execStart,
  output logic [UNIT_CNT-1:0] writeGrant,
  output logic [REG_W-1:0]    writeReg
);

  strobe_t             strb;
  logic [UNIT_CNT-1:0] unitBusy;
  logic [UNIT_CNT-1:0] opsReady;
  logic [UNIT_CNT-1:0] warFree;
  logic                wawHit;

  scb_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issueValid (issueValid),
    .issueUnit  (issueUnit),
    .unitDone   (unitDone),
    .unitBusy   (unitBusy),
    .opsReady   (opsReady),
    .warFree    (warFree),
    .wawHit     (wawHit),
    .issueReady (issueReady),
    .strb       (strb),
    .readGrant  (readGrant),
    .execStart  (execStart),
    .writeGrant (writeGrant)
  );

  scb_table table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .issueDst  (issueDst),
    .issueSrc1 (issueSrc1),
    .issueSrc2 (issueSrc2),
    .unitBusy  (unitBusy),
    .opsReady  (opsReady),
    .warFree   (warFree),
    .wawHit    (wawHit),
    .writeReg  (writeReg)
  );

endmodule

// File: tb/scoreboard_ctrl_tb_top.sv
module scoreboard_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issueValid = 1'b0;
  logic [1:0] issueUnit = '0;
  logic [4:0] issueDst = '0;
  logic [4:0] issueSrc1 = '0;
  logic [4:0] issueSrc2 = '0;
  logic [3:0] unitDone = '0;
  logic       issueReady;
  logic [3:0] readGrant;
  logic [3:0] execStart;
  logic [3:0] writeGrant;
  logic [4:0] writeReg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct { int unitIdx; int regIdx; } wexp_t;
  wexp_t expQ[$];

  always #5 clk = ~clk;

  scoreboard_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issueValid (issueValid),
    .issueUnit  (issueUnit),
    .issueDst   (issueDst),
    .issueSrc1  (issueSrc1),
    .issueSrc2  (issueSrc2),
    .unitDone   (unitDone),
    .issueReady (issueReady),
    .readGrant  (readGrant),
    .execStart  (execStart),
    .writeGrant (writeGrant),
    .writeReg   (writeReg)
  );

  task automatic check(string req, int act, int expv);
    nChecks++;
    if (act != expv) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic probe(int u, int d, int expv, string req);
    issueUnit  = 2'(u);
    issueDst   = 5'(d);
    issueSrc1  = 5'd1;
    issueSrc2  = 5'd2;
    issueValid = 1'b1;
    #1;
    check(req, int'(issueReady), expv);
    issueValid = 1'b0;
  endtask

  task automatic doIssue(int u, int d, int s1, int s2, string req);
    issueUnit  = 2'(u);
    issueDst   = 5'(d);
    issueSrc1  = 5'(s1);
    issueSrc2  = 5'(s2);
    issueValid = 1'b1;
    #1;
    check(req, int'(issueReady), 1);
    @(negedge clk);
    issueValid = 1'b0;
    #1;
  endtask

  task automatic expWrite(int u, int r);
    wexp_t e;
    e.unitIdx = u;
    e.regIdx  = r;
    expQ.push_back(e);
  endtask

  // monitor: every write grant must match the next queued expectation
  always @(negedge clk) begin
    #2;
    if (rst_n && writeGrant != 4'b0) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R7: actual grant %b reg %0d expected none", writeGrant, writeReg);
      end else begin
        wexp_t e;
        e = expQ.pop_front();
        if (writeGrant != (4'b1 << e.unitIdx) || int'(writeReg) != e.regIdx) begin
          nFails++;
          $display("FAIL R9: actual grant %b reg %0d expected unit %0d reg %0d",
                   writeGrant, writeReg, e.unitIdx, e.regIdx);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 readGrant", int'(readGrant), 0);
    check("R1 execStart", int'(execStart), 0);
    check("R1 writeGrant", int'(writeGrant), 0);
    probe(3, 9, 1, "R1 issueReady");

    // basic flow: R4, R6, R7
    doIssue(0, 3, 1, 2, "R4 accept");
    check("R4 readGrant", int'(readGrant), 4'b0001);
    tick();
    check("R6 execStart", int'(execStart), 4'b0001);
    check("R6 no reread", int'(readGrant), 0);
    unitDone = 4'b0001;
    expWrite(0, 3);
    tick();
    unitDone = 4'b0000;
    check("R6 execStart one cycle", int'(execStart), 0);
    check("R7 writeGrant", int'(writeGrant), 4'b0001);
    check("R7 writeReg", int'(writeReg), 3);
    tick();
    check("R7 grant dropped", int'(writeGrant), 0);
    probe(0, 3, 1, "R7 unit reusable");

    // structural stall: R2
    doIssue(0, 4, 1, 2, "R2 accept");
    probe(0, 9, 0, "R2 busy unit refused");
    probe(1, 9, 1, "R2 other unit accepted");
    tick();
    unitDone = 4'b0001;
    expWrite(0, 4);
    tick();
    unitDone = 4'b0000;
    tick();

    // WAW stall: R3
    doIssue(1, 5, 1, 2, "R3 accept");
    probe(2, 5, 0, "R3 same dst refused");
    probe(2, 6, 1, "R3 other dst accepted");
    tick();
    unitDone = 4'b0010;
    expWrite(1, 5);
    tick();
    unitDone = 4'b0000;
    probe(2, 5, 0, "R3 refused in write cycle");
    tick();
    probe(2, 5, 1, "R3 lifted after write");

    // RAW wait: R5
    doIssue(2, 7, 1, 2, "R5 producer");
    doIssue(1, 8, 7, 1, "R5 consumer");
    check("R5 consumer waits", int'(readGrant), 0);
    check("R6 producer exec", int'(execStart), 4'b0100);
    unitDone = 4'b0100;
    expWrite(2, 7);
    tick();
    unitDone = 4'b0000;
    check("R5 producer writes", int'(writeGrant), 4'b0100);
    check("R5 consumer still waits", int'(readGrant), 0);
    tick();
    check("R5 consumer reads", int'(readGrant), 4'b0010);
    tick();
    unitDone = 4'b0010;
    expWrite(1, 8);
    tick();
    unitDone = 4'b0000;
    tick();

    // WAR block: R8
    doIssue(2, 11, 1, 2, "R8 producer");
    doIssue(1, 13, 11, 12, "R8 reader");
    check("R8 reader waits", int'(readGrant), 0);
    doIssue(0, 12, 1, 2, "R8 writer");
    check("R8 writer reads", int'(readGrant), 4'b0001);
    tick();
    unitDone = 4'b0001;
    tick();
    unitDone = 4'b0000;
    check("R8 write held", int'(writeGrant), 0);
    unitDone = 4'b0100;
    expWrite(2, 11);
    tick();
    unitDone = 4'b0000;
    check("R8 producer writes", int'(writeGrant), 4'b0100);
    tick();
    check("R8 reader reads", int'(readGrant), 4'b0010);
    check("R8 still held", int'(writeGrant), 0);
    expWrite(0, 12);
    tick();
    check("R8 released", int'(writeGrant), 4'b0001);
    check("R8 writeReg", int'(writeReg), 12);
    unitDone = 4'b0010;
    expWrite(1, 13);
    tick();
    unitDone = 4'b0000;
    tick();

    // priority: R9
    doIssue(0, 20, 1, 2, "R9 first");
    doIssue(1, 21, 3, 4, "R9 second");
    tick();
    unitDone = 4'b0011;
    expWrite(0, 20);
    expWrite(1, 21);
    tick();
    unitDone = 4'b0000;
    check("R9 lowest first", int'(writeGrant), 4'b0001);
    tick();
    check("R9 next follows", int'(writeGrant), 4'b0010);
    tick();

    // issue during producer write: R5
    doIssue(3, 15, 1, 2, "R5 div");
    tick();
    unitDone = 4'b1000;
    expWrite(3, 15);
    tick();
    unitDone = 4'b0000;
    check("R5 div writes", int'(writeGrant), 4'b1000);
    doIssue(1, 16, 15, 15, "R5 bypass accept");
    check("R5 bypass read", int'(readGrant), 4'b0010);
    tick();
    unitDone = 4'b0010;
    expWrite(1, 16);
    tick();
    unitDone = 4'b0000;
    tick();
    tick();

    check("R9 all writes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule